// File: doc/BRIEF.md
# Multi-Line Receive Character Silo

This block is a shared receive FIFO that sits between a set of serial line receivers and a host. Each receiver hands over a finished character together with the number of its line and its parity and framing error flags. The silo keeps the characters in arrival order and shows the oldest one on a 16-bit read word. It also produces the flags the host uses to decide when to service the receive side.

Reading the word is destructive. A read strobe taken while the word is valid removes the bottom entry. The next entry is then held back for a programmable settle window before it is shown as valid. An alarm counter counts the characters stored since the most recent read strobe. When that count reaches a threshold, the alarm is raised so that an interrupt can be requested once per burst instead of once per character. A full silo drops incoming characters and marks the next character it does store with an overrun bit.

The controller has three states. `ST_IDLE` means no entry is shown. `ST_PRESENT` means the bottom entry is shown as valid. `ST_HOLDOFF` is the settle window after a removal. Its transitions are:
- idle→present when the silo holds an entry;
- present→holdoff on a read strobe;
- holdoff→present when the window ends and entries remain;
- holdoff→idle when the window ends with the silo empty;
- any state→idle on a synchronous clear.

Top module: `rx_silo`

## Requirements
- R1: After reset, or one cycle after `clr` is high, the silo is empty: `done`=0, `alarm`=0 and `rd_word`=0.
- R2: `done` is 1 exactly while at least one character is stored, including during the settle window; `rd_word[15]` is never 1 while `done` is 0.
- R3: Read word layout: bit 15 valid, bit 14 overrun, bit 13 framing error, bit 12 parity error, bits 11:10 zero, bits 9:8 line number, bits 7:0 data. When bit 15 is 0 the whole word is 0.
- R4: Characters are shown in arrival order. A read strobe in a cycle where the word is valid removes that entry.
- R5: After a removing read, the word reads as not valid for exactly `SETTLE_CYC` cycles. In the following cycle it shows the next entry if one is stored.
- R6: A read strobe while the word is not valid removes nothing; the next entry is still shown later.
- R7: `alarm` becomes 1 in the cycle after the `ALARM_AT`-th character is stored since the last read strobe, and stays 1 until a read strobe or clear.
- R8: Every read strobe, valid or not, clears `alarm` and the alarm counter; `alarm` is 0 in the following cycle.
- R9: `irq` is 0 when `rie`=0. `irq` equals `done` when `rie`=1 and `alarm_en`=0. `irq` equals `alarm` when both are 1.
- R10: A character arriving while `DEPTH` entries are stored is dropped. The next character stored carries overrun bit 14 = 1; later ones carry 0.
- R11: A character written into an empty silo shows as valid two cycles after its write strobe is sampled, not one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Synchronous clear of silo and alarm counter |
| rx_stb | input | 1 | A receiver delivers a character this cycle |
| rx_data | input | 8 | Received character |
| rx_line | input | 2 | Line number of the character |
| rx_perr | input | 1 | Parity error flag of the character |
| rx_ferr | input | 1 | Framing error flag of the character |
| rd_stb | input | 1 | Host read strobe (destructive) |
| rie | input | 1 | Receive interrupt enable |
| alarm_en | input | 1 | Use alarm instead of done for interrupts |
| rd_word | output | 16 | Bottom entry with valid bit |
| done | output | 1 | At least one character stored |
| alarm | output | 1 | Alarm threshold reached since last read |
| irq | output | 1 | Receive interrupt request |

## Verification
The assertions check the following on every cycle:
- the three interrupt modes;
- that a read always leaves the alarm low;
- that a removing read is followed by an invalid word;
- that the word is never valid while the silo is empty, and is all zero when invalid;
- that a clear empties the silo.

Only the directed scenarios can show the rest:
- arrival order and field placement;
- the exact length of the settle window;
- that a read during the window loses nothing;
- the alarm firing on the sixteenth stored character;
- that overrun is marked on the first character after a full-silo drop and on no later one.

// File: rtl/rx_silo_pkg.sv
package rx_silo_pkg;
    localparam int DATA_W = 8;
    localparam int LINE_W = 2;

    typedef struct packed {
        logic              ovr;
        logic              ferr;
        logic              perr;
        logic [LINE_W-1:0] line;
        logic [DATA_W-1:0] data;
    } silo_ent_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PRESENT,
        ST_HOLDOFF
    } silo_st_t;
endpackage

// File: rtl/rx_silo_store.sv
module rx_silo_store
    import rx_silo_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clr,
    input  logic      push,
    input  silo_ent_t din,
    input  logic      pop,
    output silo_ent_t dout,
    output logic      occ_nz,
    output logic      stored
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    silo_ent_t         mem [DEPTH];
    logic [AW-1:0]     wptr, rptr;
    logic [CW-1:0]     occ;
    logic              ovr_pend;
    logic              full;

    assign full   = (occ == CW'(DEPTH));
    assign stored = push & ~full & ~clr;
    assign occ_nz = (occ != '0);
    assign dout   = mem[rptr];

    always_ff @(posedge clk) begin
        if (stored) begin
            mem[wptr]     <= din;
            mem[wptr].ovr <= ovr_pend;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr     <= '0;
            rptr     <= '0;
            occ      <= '0;
            ovr_pend <= 1'b0;
        end else if (clr) begin
            wptr     <= '0;
            rptr     <= '0;
            occ      <= '0;
            ovr_pend <= 1'b0;
        end else begin
            if (stored)
                wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
            if (pop)
                rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
            occ <= occ + CW'(stored) - CW'(pop);
            if (push && full)
                ovr_pend <= 1'b1;
            else if (stored)
                ovr_pend <= 1'b0;
        end
    end
endmodule

// File: rtl/rx_silo_alarm.sv
module rx_silo_alarm #(
    parameter int ALARM_AT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic rd,
    input  logic stored,
    output logic alarm
);
    localparam int CW = $clog2(ALARM_AT + 1);

    logic [CW-1:0] cnt;

    assign alarm = (cnt == CW'(ALARM_AT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (rd)
            cnt <= CW'(stored);
        else if (stored && !alarm)
            cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/rx_silo_ctrl.sv
module rx_silo_ctrl
    import rx_silo_pkg::*;
#(
    parameter int SETTLE_CYC = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic have_data,
    input  logic rd,
    output logic show,
    output logic pop
);
    localparam int TW = $clog2(SETTLE_CYC + 1);

    silo_st_t      st, st_nxt;
    logic [TW-1:0] tmr;
    logic          gap_done;

    assign gap_done = (tmr == TW'(SETTLE_CYC - 1));

    // state register and settle timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            tmr <= '0;
        end else begin
            st <= st_nxt;
            if (st != ST_HOLDOFF)
                tmr <= '0;
            else
                tmr <= tmr + TW'(1);
        end
    end

    // next-state logic
    always_comb begin
        st_nxt = st;
        if (clr) begin
            st_nxt = ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE:    if (have_data) st_nxt = ST_PRESENT;
                ST_PRESENT: if (rd)        st_nxt = ST_HOLDOFF;
                ST_HOLDOFF: if (gap_done)  st_nxt = have_data ? ST_PRESENT : ST_IDLE;
                default:                   st_nxt = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        show = (st == ST_PRESENT);
        pop  = show & rd & ~clr;
    end
endmodule

// File: rtl/rx_silo.sv
module rx_silo
    import rx_silo_pkg::*;
#(
    parameter int DEPTH      = 64,
    parameter int ALARM_AT   = 16,
    parameter int SETTLE_CYC = 125
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        rx_stb,
    input  logic [7:0]  rx_data,
    input  logic [1:0]  rx_line,
    input  logic        rx_perr,
    input  logic        rx_ferr,
    input  logic        rd_stb,
    input  logic        rie,
    input  logic        alarm_en,
    output logic [15:0] rd_word,
    output logic        done,
    output logic        alarm,
    output logic        irq
);
    silo_ent_t in_ent, head;
    logic      occ_nz, stored, show, pop;

    assign in_ent = '{ovr: 1'b0, ferr: rx_ferr, perr: rx_perr, line: rx_line, data: rx_data};

    rx_silo_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .clr(clr), .push(rx_stb), .din(in_ent),
        .pop(pop), .dout(head), .occ_nz(occ_nz), .stored(stored)
    );

    rx_silo_alarm #(.ALARM_AT(ALARM_AT)) u_alarm (
        .clk(clk), .rst_n(rst_n), .clr(clr), .rd(rd_stb), .stored(stored), .alarm(alarm)
    );

    rx_silo_ctrl #(.SETTLE_CYC(SETTLE_CYC)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .clr(clr), .have_data(occ_nz), .rd(rd_stb),
        .show(show), .pop(pop)
    );

    assign rd_word = show ? {1'b1, head.ovr, head.ferr, head.perr, 2'b00, head.line, head.data}
                          : 16'h0000;
    assign done    = occ_nz;
    assign irq     = rie & (alarm_en ? alarm : occ_nz);
endmodule

// File: rtl/rx_silo_chk.sv
module rx_silo_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        clr,
    input logic        rd_stb,
    input logic        rie,
    input logic        alarm_en,
    input logic [15:0] rd_word,
    input logic        done,
    input logic        alarm,
    input logic        irq
);
    AST_QUIET_WITHOUT_RIE: assert property (@(posedge clk) disable iff (!rst_n)
        !rie |-> !irq); // R9
    AST_DONE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (rie && !alarm_en && done) |-> irq); // R9
    AST_ALARM_GATES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (rie && alarm_en && !alarm) |-> !irq); // R9
    AST_READ_DROPS_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> !alarm); // R8
    AST_GAP_AFTER_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && rd_word[15]) |=> !rd_word[15]); // R5
    AST_EMPTY_NOT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> !rd_word[15]); // R2
    AST_INVALID_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_word[15] |-> (rd_word == 16'h0000)); // R3
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!done && !alarm)); // R1
endmodule

bind rx_silo rx_silo_chk u_chk (
    .clk(clk), .rst_n(rst_n), .clr(clr), .rd_stb(rd_stb), .rie(rie),
    .alarm_en(alarm_en), .rd_word(rd_word), .done(done), .alarm(alarm), .irq(irq)
);

// File: tb/rx_silo_tb.sv
module rx_silo_tb;
    localparam int S = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0, rx_stb = 1'b0, rx_perr = 1'b0, rx_ferr = 1'b0;
    logic [7:0]  rx_data = '0;
    logic [1:0]  rx_line = '0;
    logic        rd_stb = 1'b0, rie = 1'b0, alarm_en = 1'b0;
    logic [15:0] rd_word;
    logic        done, alarm, irq;
    int          n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    rx_silo #(.DEPTH(64), .ALARM_AT(16), .SETTLE_CYC(S)) u_dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .rx_stb(rx_stb), .rx_data(rx_data),
        .rx_line(rx_line), .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rd_stb(rd_stb),
        .rie(rie), .alarm_en(alarm_en), .rd_word(rd_word), .done(done),
        .alarm(alarm), .irq(irq)
    );

    function automatic logic [15:0] mk(input logic o, input logic f, input logic p,
                                       input logic [1:0] l, input logic [7:0] d);
        return {1'b1, o, f, p, 2'b00, l, d};
    endfunction

    task automatic chk(input logic ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic push(input logic [1:0] l, input logic [7:0] d, input logic p, input logic f);
        @(negedge clk);
        rx_stb = 1'b1; rx_line = l; rx_data = d; rx_perr = p; rx_ferr = f;
        @(negedge clk);
        rx_stb = 1'b0;
    endtask

    task automatic pop_expect(input logic [15:0] exp, input string req);
        int n = 0;
        @(negedge clk);
        while (!rd_word[15] && n < S + 4) begin
            @(negedge clk);
            n++;
        end
        chk(rd_word == exp, req, rd_word, exp);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic do_clear();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    task automatic t_reset();
        rie = 1'b1;
        @(negedge clk);
        chk(rd_word == 16'h0 && !done && !alarm, "R1", {13'b0, done, alarm, rd_word[15]}, 16'h0);
        chk(!irq, "R9", {15'b0, irq}, 16'h0);
        rie = 1'b0;
    endtask

    task automatic t_basic();
        push(2'd1, 8'h5A, 1'b1, 1'b0);
        chk(done, "R2", {15'b0, done}, 16'h1);
        chk(!rd_word[15], "R11", rd_word, 16'h0);
        @(negedge clk);
        chk(rd_word == mk(0, 0, 1, 2'd1, 8'h5A), "R11", rd_word, mk(0, 0, 1, 2'd1, 8'h5A));
        push(2'd3, 8'hC3, 1'b0, 1'b1);
        push(2'd0, 8'h00, 1'b0, 1'b0);
        pop_expect(mk(0, 0, 1, 2'd1, 8'h5A), "R4");
        for (int i = 0; i < S; i++) begin
            chk(!rd_word[15], "R5", rd_word, 16'h0);
            chk(done, "R2", {15'b0, done}, 16'h1);
            if (i < S - 1) @(negedge clk);
        end
        @(negedge clk);
        chk(rd_word == mk(0, 1, 0, 2'd3, 8'hC3), "R5", rd_word, mk(0, 1, 0, 2'd3, 8'hC3));
        pop_expect(mk(0, 1, 0, 2'd3, 8'hC3), "R3");
        pop_expect(mk(0, 0, 0, 2'd0, 8'h00), "R4");
        chk(!done, "R2", {15'b0, done}, 16'h0);
        repeat (S + 2) @(negedge clk);
        chk(rd_word == 16'h0, "R3", rd_word, 16'h0);
    endtask

    task automatic t_gap_read();
        push(2'd2, 8'h11, 1'b0, 1'b0);
        push(2'd2, 8'h22, 1'b0, 1'b0);
        pop_expect(mk(0, 0, 0, 2'd2, 8'h11), "R4");
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        repeat (S + 2) @(negedge clk);
        chk(rd_word == mk(0, 0, 0, 2'd2, 8'h22), "R6", rd_word, mk(0, 0, 0, 2'd2, 8'h22));
        pop_expect(mk(0, 0, 0, 2'd2, 8'h22), "R6");
        chk(!done, "R6", {15'b0, done}, 16'h0);
    endtask

    task automatic t_alarm();
        do_clear();
        chk(!done && !alarm, "R1", {14'b0, done, alarm}, 16'h0);
        rie = 1'b1; alarm_en = 1'b1;
        for (int i = 0; i < 15; i++) push(2'd0, 8'(i), 1'b0, 1'b0);
        chk(!alarm, "R7", {15'b0, alarm}, 16'h0);
        chk(!irq, "R9", {15'b0, irq}, 16'h0);
        push(2'd1, 8'hF0, 1'b0, 1'b0);
        chk(alarm, "R7", {15'b0, alarm}, 16'h1);
        chk(irq, "R9", {15'b0, irq}, 16'h1);
        repeat (3) @(negedge clk);
        chk(alarm, "R7", {15'b0, alarm}, 16'h1);
        alarm_en = 1'b0;
        @(negedge clk);
        chk(irq, "R9", {15'b0, irq}, 16'h1);
        rie = 1'b0; alarm_en = 1'b1;
        @(negedge clk);
        chk(!irq, "R9", {15'b0, irq}, 16'h0);
        rie = 1'b1;
        pop_expect(mk(0, 0, 0, 2'd0, 8'h00), "R4");
        chk(!alarm, "R8", {15'b0, alarm}, 16'h0);
        chk(!irq, "R9", {15'b0, irq}, 16'h0);
        chk(done, "R2", {15'b0, done}, 16'h1);
        rie = 1'b0; alarm_en = 1'b0;
        do_clear();
        chk(!done && rd_word == 16'h0, "R1", rd_word, 16'h0);
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 64; i++) push(2'(i), 8'(i), 1'b0, 1'b0);
        push(2'd1, 8'hEE, 1'b0, 1'b0);
        push(2'd1, 8'hEF, 1'b0, 1'b0);
        for (int i = 0; i < 64; i++) pop_expect(mk(0, 0, 0, 2'(i), 8'(i)), "R10");
        chk(!done, "R10", {15'b0, done}, 16'h0);
        push(2'd2, 8'h77, 1'b0, 1'b0);
        pop_expect(mk(1, 0, 0, 2'd2, 8'h77), "R10");
        push(2'd2, 8'h78, 1'b0, 1'b0);
        pop_expect(mk(0, 0, 0, 2'd2, 8'h78), "R10");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_gap_read();
        t_alarm();
        t_overflow();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule